// File: doc/BRIEF.md
# Multidrop Asynchronous Serial Receiver

This block turns an asynchronous serial line into 8-bit or 9-bit words and hands them to a host through a two-word holding buffer. The line is sampled on a 16x oversampling tick supplied from outside. Each bit is decided by a majority vote of three samples taken around its middle. A start bit must still read low at its midpoint, so short glitches on an idle line do not begin a frame.

For multidrop buses the receiver can run in an address-detect mode. There, in 9-bit framing, only words with a ninth bit of 1 enter the buffer and raise the interrupt, and data words meant for other nodes are dropped. With address detect off, the ninth bit is plain data such as parity. Each buffered word carries its own ninth bit and framing status. A buffer that is already full when a word completes sets a sticky overrun flag, and reception stops until software clears the continuous-receive bit.

The host writes a 4-bit control register, reads the word at the head of the buffer with a one-cycle pop, and sees a level interrupt whenever the buffer holds a word.

Top module: `mdrop_rx`

## Requirements
- R1: After a synchronous active-low reset, every control bit reads 0 and `rx_irq`, `ovr_err`, `rd_data`, `rd_bit9` and `rd_ferr` are all 0.
- R2: Control bits are bit0 enable, bit1 nine-bit mode, bit2 continuous receive and bit3 address detect. A frame is received only while both enable and continuous receive are 1. While enable is 0 the buffer is emptied and `ovr_err` is cleared.
- R3: In 8-bit mode a frame is one low start bit, 8 data bits sent LSB first and a stop bit. `rd_bit9` reads 0 and the address-detect bit has no effect.
- R4: In 9-bit mode a ninth data bit follows the eight and appears on `rd_bit9`. With address detect at 0, every word is buffered whatever its ninth bit.
- R5: In 9-bit mode with address detect at 1, a word whose ninth bit is 0 is discarded and does not raise `rx_irq`. A word whose ninth bit is 1 is buffered.
- R6: A stop bit that votes low still stores the word, with its framing flag set. `rd_ferr` shows the flag of the word at the head of the buffer, so it changes when that word is popped.
- R7: Each bit is the majority of three samples at ticks 7, 8 and 9 of its 16 ticks. A start bit that does not vote low at its middle is rejected, and the receiver then waits for a new falling edge.
- R8: The buffer holds two words in arrival order. `rx_irq` is 1 exactly while it is non-empty, and each `rd_pop` removes the head word.
- R9: A word that completes while the buffer is full and not being popped sets `ovr_err` and is dropped. While `ovr_err` is 1 no frame is accepted, and buffered words stay readable. Clearing continuous receive clears `ovr_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_pin | input | 1 | Serial receive line, idle high, asynchronous |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 4 | Control value: bit0 enable, bit1 nine-bit, bit2 continuous, bit3 address detect |
| ctl_q | output | 4 | Current control register value |
| rd_pop | input | 1 | Removes the head word from the buffer |
| rd_data | output | 8 | Data bits of the head word (0 when empty) |
| rd_bit9 | output | 1 | Ninth bit of the head word (0 when empty) |
| rd_ferr | output | 1 | Framing flag of the head word (0 when empty) |
| ovr_err | output | 1 | Sticky overrun flag |
| rx_irq | output | 1 | Receive-ready interrupt, high while the buffer is non-empty |

## Verification
The overrun condition is the hardest state to reach from the ports. It needs two complete, accepted frames left unread, then a third frame that completes into the full buffer, and then a fourth frame that must be proven ignored. The bench sends these frames back to back without popping. It then pops both survivors to show their order and that the dropped words never appear, and finally clears continuous receive to release the flag. False starts are produced with a low pulse shorter than half a bit, so the midpoint vote of the start bit reads high.

// File: rtl/mdrop_rx_pkg.sv
// Shared types for the multidrop receiver.
// Assumes: one word is 8 data bits, a ninth bit and a framing flag.
package mdrop_rx_pkg;
    typedef enum logic {RX_IDLE, RX_BITS} rx_state_e;

    typedef struct packed {
        logic       bad;
        logic       b9;
        logic [7:0] data;
    } rx_word_t;

    localparam int CTL_EN   = 0;
    localparam int CTL_NINE = 1;
    localparam int CTL_CONT = 2;
    localparam int CTL_ADET = 3;
endpackage

// File: rtl/mdrop_rx_sampler.sv
// Oversampling frame decoder: synchronises the line, votes three mid-bit
// samples and shifts data in LSB first. It raises done for one cycle with
// the word and the stop-bit status.
// Assumes: tick is a one-cycle pulse at OSR times the bit rate, and the
// caller drops run to abort a frame and return to idle.
module mdrop_rx_sampler
    import mdrop_rx_pkg::*;
#(
    parameter int OSR  = 16,
    parameter int MAXB = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            nine,
    input  logic            tick,
    input  logic            rx_pin,
    output logic            done,
    output logic [MAXB-1:0] word,
    output logic            stop_bad
);
    localparam int CW  = $clog2(OSR);
    localparam int IW  = $clog2(MAXB + 2);
    localparam int MID = OSR / 2;

    logic [1:0]      sync_q;
    logic            rx_s;
    rx_state_e       st_q;
    logic [CW-1:0]   cnt_q;
    logic [IW-1:0]   idx_q;
    logic [IW-1:0]   last_idx;
    logic [2:0]      smp_q;
    logic            vote_hi;
    logic [MAXB-1:0] sh_q;
    logic            done_q;
    logic            bad_q;

    // Two-stage synchroniser for the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rx_pin};
    end

    assign rx_s     = sync_q[1];
    assign vote_hi  = (smp_q[0] & smp_q[1]) | (smp_q[0] & smp_q[2]) | (smp_q[1] & smp_q[2]);
    assign last_idx = nine ? IW'(MAXB + 1) : IW'(MAXB);

    // Frame state machine: start detect, per-bit vote, shift, stop check.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            st_q   <= RX_IDLE;
            cnt_q  <= '0;
            idx_q  <= '0;
            smp_q  <= '0;
            sh_q   <= '0;
            done_q <= 1'b0;
            bad_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (tick) begin
                case (st_q)
                    RX_IDLE: begin
                        if (!rx_s) begin
                            st_q  <= RX_BITS;
                            cnt_q <= '0;
                            idx_q <= '0;
                        end
                    end
                    RX_BITS: begin
                        cnt_q <= (cnt_q == CW'(OSR - 1)) ? '0 : cnt_q + 1'b1;
                        if (cnt_q == CW'(MID - 1) || cnt_q == CW'(MID) || cnt_q == CW'(MID + 1))
                            smp_q <= {smp_q[1:0], rx_s};
                        if (cnt_q == CW'(OSR - 1)) begin
                            if (idx_q == '0) begin
                                if (vote_hi) st_q <= RX_IDLE;
                                else         idx_q <= idx_q + 1'b1;
                            end else if (idx_q == last_idx) begin
                                done_q <= 1'b1;
                                bad_q  <= !vote_hi;
                                st_q   <= RX_IDLE;
                            end else begin
                                sh_q  <= {vote_hi, sh_q[MAXB-1:1]};
                                idx_q <= idx_q + 1'b1;
                            end
                        end
                    end
                    default: st_q <= RX_IDLE;
                endcase
            end
        end
    end

    assign done     = done_q;
    assign stop_bad = bad_q;
    assign word     = nine ? sh_q : {1'b0, sh_q[MAXB-1:1]};
endmodule

// File: rtl/mdrop_rx_fifo.sv
// Small holding FIFO with a combinational head output (zero when empty).
// Assumes: DEPTH is a power of two of at least 2, and the caller pushes
// only when there is room (or a pop happens in the same cycle).
module mdrop_rx_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] fill
);
    localparam int PW = $clog2(DEPTH);
    localparam int FW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [FW-1:0] cnt_q;
    logic          do_pop;

    assign do_pop = pop && (cnt_q != '0);

    // Storage write at the write pointer.
    always_ff @(posedge clk) begin
        if (push) mem_q[wp_q] <= din;
    end

    // Pointer and occupancy update, flushed on reset or request.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push)   wp_q <= wp_q + 1'b1;
            if (do_pop) rp_q <= rp_q + 1'b1;
            cnt_q <= cnt_q + FW'(push) - FW'(do_pop);
        end
    end

    assign dout = (cnt_q != '0) ? mem_q[rp_q] : '0;
    assign fill = cnt_q;
endmodule

// File: rtl/mdrop_rx.sv
// Top of the multidrop receiver: control register, address filter,
// overrun tracking and host-facing buffer outputs.
// Assumes: os_tick comes from an external baud generator at 16x the rate.
module mdrop_rx
    import mdrop_rx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_pin,
    input  logic       os_tick,
    input  logic       ctl_we,
    input  logic [3:0] ctl_wdata,
    output logic [3:0] ctl_q,
    input  logic       rd_pop,
    output logic [7:0] rd_data,
    output logic       rd_bit9,
    output logic       rd_ferr,
    output logic       ovr_err,
    output logic       rx_irq
);
    localparam int WW = $bits(rx_word_t);
    localparam int FW = $clog2(DEPTH + 1);

    logic [3:0]    ctl_r;
    logic          oerr_q;
    logic          run;
    logic          fr_done, fr_bad;
    logic [8:0]    fr_word;
    logic          accept, room, push, overrun;
    rx_word_t      in_w, head_w;
    logic [FW-1:0] fill;

    // Control register, written whole by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_r <= '0;
        else if (ctl_we) ctl_r <= ctl_wdata;
    end

    assign run = ctl_r[CTL_EN] && ctl_r[CTL_CONT] && !oerr_q;

    mdrop_rx_sampler #(.OSR(OSR), .MAXB(9)) u_smp (
        .clk(clk), .rst_n(rst_n), .run(run), .nine(ctl_r[CTL_NINE]),
        .tick(os_tick), .rx_pin(rx_pin),
        .done(fr_done), .word(fr_word), .stop_bad(fr_bad)
    );

    assign accept  = fr_done && !(ctl_r[CTL_NINE] && ctl_r[CTL_ADET] && !fr_word[8]);
    assign room    = (fill != FW'(DEPTH)) || rd_pop;
    assign push    = accept && room;
    assign overrun = accept && !room;
    assign in_w    = '{bad: fr_bad, b9: fr_word[8], data: fr_word[7:0]};

    mdrop_rx_fifo #(.W(WW), .DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n), .flush(!ctl_r[CTL_EN]),
        .push(push), .din(in_w), .pop(rd_pop), .dout(head_w), .fill(fill)
    );

    // Sticky overrun flag, released by clearing enable or continuous receive.
    always_ff @(posedge clk) begin
        if (!rst_n || !ctl_r[CTL_EN] || !ctl_r[CTL_CONT]) oerr_q <= 1'b0;
        else if (overrun)                                 oerr_q <= 1'b1;
    end

    assign ctl_q   = ctl_r;
    assign rd_data = head_w.data;
    assign rd_bit9 = head_w.b9;
    assign rd_ferr = head_w.bad;
    assign ovr_err = oerr_q;
    assign rx_irq  = (fill != '0);
endmodule

// File: rtl/mdrop_rx_chk.sv
// Assertion checker for mdrop_rx, attached with bind below.
module mdrop_rx_chk #(
    parameter int FW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    ctl_q,
    input logic          rd_pop,
    input logic          rx_irq,
    input logic          ovr_err,
    input logic          push,
    input logic          word_b9,
    input logic [FW-1:0] fill
);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (ctl_q == 4'h0 && !rx_irq && !ovr_err));

    a_r2_disable_flushes: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q[0] |=> (!rx_irq && !ovr_err));

    a_r5_addr_only: assert property (@(posedge clk) disable iff (!rst_n)
        (push && ctl_q[1] && ctl_q[3]) |-> word_b9);

    a_r8_last_pop_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && rx_irq && fill == FW'(1) && !push) |=> !rx_irq);

    a_r9_stall_on_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_err |-> !push);

    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_err && ctl_q[0] && ctl_q[2]) |=> ovr_err);
endmodule

bind mdrop_rx mdrop_rx_chk #(.FW(FW)) chk_i (
    .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .rd_pop(rd_pop),
    .rx_irq(rx_irq), .ovr_err(ovr_err), .push(push),
    .word_b9(fr_word[8]), .fill(fill)
);

// File: tb/mdrop_rx_tb.sv
// Self-checking bench for mdrop_rx: vector table walk, then directed cases.
module mdrop_rx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_pin = 1'b1;
    logic       os_tick = 1'b0;
    logic       ctl_we = 1'b0;
    logic [3:0] ctl_wdata = 4'h0;
    logic [3:0] ctl_q;
    logic       rd_pop = 1'b0;
    logic [7:0] rd_data;
    logic       rd_bit9, rd_ferr, ovr_err, rx_irq;

    int n_chk = 0;
    int n_bad = 0;

    localparam int BITCLK = 64; // 16 ticks of 4 clocks

    // Vector: {nine, adet, stop, data9[8:0], exp_push, exp_b9, exp_ferr, exp_data[7:0]}
    localparam int NV = 8;
    localparam logic [22:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b1, 9'h0A5, 1'b1, 1'b0, 1'b0, 8'hA5},  // R3 plain byte
        {1'b0, 1'b1, 1'b1, 9'h03C, 1'b1, 1'b0, 1'b0, 8'h3C},  // R3 adet ignored
        {1'b1, 1'b0, 1'b1, 9'h15A, 1'b1, 1'b1, 1'b0, 8'h5A},  // R4 ninth 1
        {1'b1, 1'b0, 1'b1, 9'h081, 1'b1, 1'b0, 1'b0, 8'h81},  // R4 ninth 0 kept
        {1'b1, 1'b1, 1'b1, 9'h177, 1'b1, 1'b1, 1'b0, 8'h77},  // R5 address word
        {1'b1, 1'b1, 1'b1, 9'h066, 1'b0, 1'b0, 1'b0, 8'h00},  // R5 data word dropped
        {1'b0, 1'b0, 1'b0, 9'h0F0, 1'b1, 1'b0, 1'b1, 8'hF0},  // R6 bad stop
        {1'b1, 1'b1, 1'b0, 9'h10F, 1'b1, 1'b1, 1'b1, 8'h0F}   // R6 bad stop, address
    };

    mdrop_rx dut_i (
        .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .os_tick(os_tick),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
        .rd_pop(rd_pop), .rd_data(rd_data), .rd_bit9(rd_bit9),
        .rd_ferr(rd_ferr), .ovr_err(ovr_err), .rx_irq(rx_irq)
    );

    always #4 clk = ~clk; // 125 MHz

    // Oversampling tick: one pulse every 4 clocks.
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            os_tick = 1'b1;
            @(negedge clk);
            os_tick = 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [3:0] v);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic pop1();
        @(negedge clk);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    task automatic idle_bits(input int n);
        rx_pin = 1'b1;
        repeat (n * BITCLK) @(negedge clk);
    endtask

    task automatic send(input logic nine, input logic [8:0] d, input logic stop);
        @(negedge clk);
        rx_pin = 1'b0;
        repeat (BITCLK) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            rx_pin = d[k];
            repeat (BITCLK) @(negedge clk);
        end
        if (nine) begin
            rx_pin = d[8];
            repeat (BITCLK) @(negedge clk);
        end
        rx_pin = stop;
        repeat (BITCLK) @(negedge clk);
        rx_pin = 1'b1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctl", ctl_q, 4'h0);
        chk("R1 irq", rx_irq, 1'b0);
        chk("R1 oerr", ovr_err, 1'b0);
        chk("R1 head", {rd_bit9, rd_ferr, rd_data}, 10'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            wr_ctl({VEC[i][21], 1'b1, VEC[i][22], 1'b1});
            send(VEC[i][22], VEC[i][19:11], VEC[i][20]);
            idle_bits(2);
            chk("R8/R5 irq after frame", rx_irq, VEC[i][10]);
            if (VEC[i][10]) begin
                chk("R3/R4 data", rd_data, VEC[i][7:0]);
                chk("R4 ninth", rd_bit9, VEC[i][9]);
                chk("R6 ferr", rd_ferr, VEC[i][8]);
                pop1();
                chk("R8 empty after pop", rx_irq, 1'b0);
            end
        end

        // R7 false start glitch rejected, then a real frame still decodes
        wr_ctl(4'b0101);
        @(negedge clk);
        rx_pin = 1'b0;
        repeat (16) @(negedge clk);
        rx_pin = 1'b1;
        idle_bits(3);
        chk("R7 glitch ignored", rx_irq, 1'b0);
        send(1'b0, 9'h055, 1'b1);
        idle_bits(2);
        chk("R7 frame after glitch", rd_data, 8'h55);
        pop1();

        // R6 framing flag follows the head word
        send(1'b0, 9'h011, 1'b0);
        idle_bits(2);
        send(1'b0, 9'h022, 1'b1);
        idle_bits(2);
        chk("R6 head ferr", rd_ferr, 1'b1);
        chk("R8 order first", rd_data, 8'h11);
        pop1();
        chk("R6 ferr after pop", rd_ferr, 1'b0);
        chk("R8 order second", rd_data, 8'h22);
        pop1();
        chk("R8 drained", rx_irq, 1'b0);

        // R9 overrun: third word into a full buffer, fourth ignored
        send(1'b0, 9'h0A1, 1'b1);
        idle_bits(1);
        send(1'b0, 9'h0A2, 1'b1);
        idle_bits(1);
        chk("R9 no overrun at full", ovr_err, 1'b0);
        send(1'b0, 9'h0A3, 1'b1);
        idle_bits(1);
        chk("R9 overrun set", ovr_err, 1'b1);
        send(1'b0, 9'h0A4, 1'b1);
        idle_bits(1);
        chk("R9 irq held", rx_irq, 1'b1);
        chk("R9 first kept", rd_data, 8'hA1);
        pop1();
        chk("R9 second kept", rd_data, 8'hA2);
        pop1();
        chk("R9 dropped words absent", rx_irq, 1'b0);
        chk("R9 still sticky", ovr_err, 1'b1);
        wr_ctl(4'b0001);
        @(negedge clk);
        chk("R9 cleared by cont", ovr_err, 1'b0);
        wr_ctl(4'b0101);
        send(1'b0, 9'h0B7, 1'b1);
        idle_bits(2);
        chk("R9 reception resumes", rd_data, 8'hB7);
        pop1();

        // R2 gating by enable and continuous receive
        wr_ctl(4'b0001);
        send(1'b0, 9'h033, 1'b1);
        idle_bits(2);
        chk("R2 no cont no rx", rx_irq, 1'b0);
        wr_ctl(4'b0100);
        chk("R2 ctl readback", ctl_q, 4'b0100);
        send(1'b0, 9'h033, 1'b1);
        idle_bits(2);
        chk("R2 no enable no rx", rx_irq, 1'b0);
        wr_ctl(4'b0101);
        send(1'b0, 9'h044, 1'b1);
        idle_bits(2);
        chk("R2 enabled rx", rx_irq, 1'b1);
        wr_ctl(4'b0100);
        @(negedge clk);
        chk("R2 disable flushes", rx_irq, 1'b0);
        wr_ctl(4'b0101);
        @(negedge clk);
        chk("R2 stays empty", {rx_irq, rd_data}, 9'h0);

        finish_run();
    end
endmodule